// File: doc/BRIEF.md
# Programmable Clock Enable Divider

The block turns two oscillator tick streams into three clock enables for the rest of a chip. A fast tick and a slow tick come in, and each is a single-cycle strobe in the system clock domain. The main, sub and auxiliary enables each pick one of these sources and divide its rate by 1, 2, 4 or 8. Each output is a one-cycle pulse in the same system clock domain, so downstream logic gates its flops with the pulse and needs no second clock.

Software programs the block through four byte registers on a plain write/read port. The registers hold the source selects, the divider exponents and the oscillator tuning fields. From the tuning fields the block decodes which of a small set of known frequency settings is currently programmed, and reports it as a preset code. A change to an output's select or divider restarts that output's counter, so the first pulse after a change comes one full new period later.

Top module: `clk_src_div`

## Requirements
- R1: After reset the registers read 0x60 (address 0, oscillator control), 0x87 (address 1, control 1), 0x00 (address 2, control 2) and 0x05 (address 3, control 3), all enables are low, and preset_o is 1.
- R2: A write lands on the clock edge that samples wr_en_i; before that edge rdata_o still shows the old byte, and after it rdata_o returns the written byte unchanged for the addressed register.
- R3: The main select is control 2 bits 7:6: 00 and 01 take the fast tick, 11 takes the slow tick, and 10 gives no main pulses at all.
- R4: The main divider exponent is control 2 bits 5:4; main_en_o pulses once per 2^n selected ticks.
- R5: Control 2 bit 3 selects the sub source (0 fast, 1 slow), and control 2 bits 2:1 hold its divider exponent n, giving one pulse per 2^n ticks.
- R6: The auxiliary enable always counts slow ticks, divided by 2^n where n is control 1 bits 5:4.
- R7: When an output's select or divider field changes, its counter restarts from zero: no pulse comes in the cycle after the change, and the first pulse follows the 2^n-th selected tick after it.
- R8: Each enable rises only in the cycle after a tick of its selected source.
- R9: With step = address 0 bits 7:5 and range = address 1 bits 3:0, preset_o is 1 for step 3/range 7, 2 for step 4/range 15, 3 for step 4/range 14, 4 for step 4/range 13, 5 for step 6/range 6, and 0 for every other pair; address 0 bits 4:0 have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_tick_i | input | 1 | Fast oscillator tick strobe |
| slow_tick_i | input | 1 | Low-frequency oscillator tick strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| main_en_o | output | 1 | Main clock enable pulse |
| sub_en_o | output | 1 | Sub clock enable pulse |
| aux_en_o | output | 1 | Auxiliary clock enable pulse |
| preset_o | output | 3 | Decoded frequency preset code |

## Verification
The assertions assume that ticks are single-cycle strobes sampled on the system clock. They also assume that a register write is a one-cycle strobe with a stable address and data. The stimulus drives ticks and writes just after a rising edge and keeps ticks low while a register is written and during the restart cycle after it. The sweeps pass 48 fast ticks and 16 slow ticks per run. Both numbers are multiples of every divisor, so every counter is back at zero before the next configuration starts.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int DIV_W    = 2;
  localparam int NUM_OUT  = 3;
  localparam int CFG_W    = DIV_W + 2;

  localparam logic [ADDR_W-1:0] A_OSC  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTL1 = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTL2 = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTL3 = 2'd3;

  typedef enum logic [2:0] {
    PRE_NONE = 3'd0,
    PRE_DEF  = 3'd1,
    PRE_16M  = 3'd2,
    PRE_12M  = 3'd3,
    PRE_8M   = 3'd4,
    PRE_1M   = 3'd5
  } preset_e;

  function automatic logic [DATA_W-1:0] reg_rst(input int idx);
    case (idx)
      0:       return 8'h60;
      1:       return 8'h87;
      3:       return 8'h05;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clk_div_regs.sv
module clk_div_regs
  import clk_div_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    main_sel_o,
  output logic [DIV_W-1:0] main_exp_o,
  output logic          sub_sel_o,
  output logic [DIV_W-1:0] sub_exp_o,
  output logic [DIV_W-1:0] aux_exp_o,
  output logic [3:0]    range_o,
  output logic [2:0]    step_o
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] reg_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= reg_rst(i);
    end else if (wr_en_i) begin
      reg_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o    = reg_q[addr_i];
  assign main_sel_o = reg_q[A_CTL2][7:6];
  assign main_exp_o = reg_q[A_CTL2][5:4];
  assign sub_sel_o  = reg_q[A_CTL2][3];
  assign sub_exp_o  = reg_q[A_CTL2][2:1];
  assign aux_exp_o  = reg_q[A_CTL1][5:4];
  assign range_o    = reg_q[A_CTL1][3:0];
  assign step_o     = reg_q[A_OSC][7:5];
endmodule

// File: rtl/clk_div_counter.sv
module clk_div_counter
  import clk_div_pkg::*;
#(
  parameter int EW = DIV_W,
  parameter int CW = CFG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [EW-1:0] exp_i,
  input  logic [CW-1:0] cfg_i,
  output logic          en_o
);
  localparam int CNT_W = (1 << EW) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim;
  logic [CW-1:0]    cfg_q;
  logic             restart, last, en_q;

  assign lim     = (CNT_W+1)'(1) << exp_i;
  assign last    = (cnt_q == CNT_W'(lim - 1'b1));
  assign restart = (cfg_i != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cfg_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_i;
      en_q  <= !restart && tick_i && last;
      if (restart)     cnt_q <= '0;
      else if (tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/clk_div_preset_dec.sv
module clk_div_preset_dec
  import clk_div_pkg::*;
(
  input  logic [2:0] step_i,
  input  logic [3:0] range_i,
  output preset_e    preset_o
);
  always_comb begin
    preset_o = PRE_NONE;
    unique case (step_i)
      3'd3: if (range_i == 4'd7) preset_o = PRE_DEF;
      3'd4: begin
        if (range_i == 4'd15)      preset_o = PRE_16M;
        else if (range_i == 4'd14) preset_o = PRE_12M;
        else if (range_i == 4'd13) preset_o = PRE_8M;
      end
      3'd6: if (range_i == 4'd6) preset_o = PRE_1M;
      default: preset_o = PRE_NONE;
    endcase
  end
endmodule

// File: rtl/clk_src_div.sv
module clk_src_div
  import clk_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              main_en_o,
  output logic              sub_en_o,
  output logic              aux_en_o,
  output logic [2:0]        preset_o
);
  logic [1:0]       main_sel;
  logic             sub_sel;
  logic [DIV_W-1:0] main_exp, sub_exp, aux_exp;
  logic [3:0]       range_sel;
  logic [2:0]       dco_step;
  preset_e          preset;

  logic             src_tick [NUM_OUT];
  logic [DIV_W-1:0] div_exp  [NUM_OUT];
  logic [CFG_W-1:0] div_cfg  [NUM_OUT];
  logic             en       [NUM_OUT];

  clk_div_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .main_sel_o(main_sel), .main_exp_o(main_exp),
    .sub_sel_o(sub_sel),   .sub_exp_o(sub_exp),
    .aux_exp_o(aux_exp),   .range_o(range_sel), .step_o(dco_step)
  );

  // main: 10 selects the absent oscillator
  always_comb begin
    unique case (main_sel)
      2'b00, 2'b01: src_tick[0] = fast_tick_i;
      2'b11:        src_tick[0] = slow_tick_i;
      default:      src_tick[0] = 1'b0;
    endcase
  end
  assign src_tick[1] = sub_sel ? slow_tick_i : fast_tick_i;
  assign src_tick[2] = slow_tick_i;

  assign div_exp[0] = main_exp;
  assign div_exp[1] = sub_exp;
  assign div_exp[2] = aux_exp;
  assign div_cfg[0] = {main_sel, main_exp};
  assign div_cfg[1] = {1'b0, sub_sel, sub_exp};
  assign div_cfg[2] = {2'b00, aux_exp};

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
    clk_div_counter u_cnt (
      .clk_i, .rst_ni,
      .tick_i(src_tick[g]), .exp_i(div_exp[g]), .cfg_i(div_cfg[g]),
      .en_o(en[g])
    );
  end

  assign main_en_o = en[0];
  assign sub_en_o  = en[1];
  assign aux_en_o  = en[2];

  clk_div_preset_dec u_dec (
    .step_i(dco_step), .range_i(range_sel), .preset_o(preset)
  );
  assign preset_o = preset;
endmodule

// File: rtl/clk_src_div_chk.sv
module clk_src_div_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [1:0] main_sel,
  input logic [1:0] main_exp,
  input logic [2:0] dco_step,
  input logic       fast_tick_i,
  input logic       slow_tick_i,
  input logic       sub_sel,
  input logic       main_en_o,
  input logic       sub_en_o,
  input logic       aux_en_o,
  input logic [2:0] preset_o
);
  assert_ctl2_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> (main_sel == $past(wdata_i[7:6])));

  assert_main_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(main_sel) == 2'b10) |-> !main_en_o);

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({main_sel, main_exp} != $past({main_sel, main_exp})) |=> !main_en_o);

  assert_main_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_en_o |-> ($past(fast_tick_i) || $past(slow_tick_i)));

  assert_sub_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_en_o |-> ($past(sub_sel) ? $past(slow_tick_i) : $past(fast_tick_i)));

  assert_aux_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_en_o |-> $past(slow_tick_i));

  assert_preset_none_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dco_step != 3'd3 && dco_step != 3'd4 && dco_step != 3'd6) |-> (preset_o == 3'd0));
endmodule

bind clk_src_div clk_src_div_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .main_sel(main_sel), .main_exp(main_exp),
  .dco_step(dco_step), .fast_tick_i(fast_tick_i), .slow_tick_i(slow_tick_i),
  .sub_sel(sub_sel), .main_en_o(main_en_o), .sub_en_o(sub_en_o),
  .aux_en_o(aux_en_o), .preset_o(preset_o)
);

// File: tb/tb_clk_src_div.sv
`timescale 1ns/1ps
module tb_clk_src_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast = 1'b0, slow = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       main_en, sub_en, aux_en;
  logic [2:0] preset;

  int checks = 0, errors = 0;
  int n_main = 0, n_sub = 0, n_aux = 0;
  bit count_en = 0, done = 0;

  always #2.5 clk = ~clk;

  clk_src_div dut (
    .clk_i(clk), .rst_ni(rst_n), .fast_tick_i(fast), .slow_tick_i(slow),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .main_en_o(main_en), .sub_en_o(sub_en), .aux_en_o(aux_en), .preset_o(preset)
  );

  always @(negedge clk) if (count_en) begin
    n_main += int'(main_en);
    n_sub  += int'(sub_en);
    n_aux  += int'(aux_en);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  task automatic zero_counts();
    n_main = 0; n_sub = 0; n_aux = 0;
  endtask

  // fast every cycle, slow every third cycle
  task automatic ticks(input int n, input bit use_slow);
    count_en = 1;
    for (int i = 0; i < n; i++) begin
      fast = 1'b1;
      slow = use_slow && (i % 3 == 2);
      @(posedge clk); #1;
    end
    fast = 1'b0; slow = 1'b0;
    idle(2);
    count_en = 0;
  endtask

  function automatic int main_exp_cnt(input int sel, input int ex);
    if (sel == 2) return 0;
    if (sel == 3) return 16 >> ex;
    return 48 >> ex;
  endfunction

  function automatic int preset_exp(input int st, input int rg);
    if (st == 3 && rg == 7)  return 1;
    if (st == 4 && rg == 15) return 2;
    if (st == 4 && rg == 14) return 3;
    if (st == 4 && rg == 13) return 4;
    if (st == 6 && rg == 6)  return 5;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(2'd0, v); chk("R1 osc", v, 'h60);
    rd(2'd1, v); chk("R1 ctl1", v, 'h87);
    rd(2'd2, v); chk("R1 ctl2", v, 'h00);
    rd(2'd3, v); chk("R1 ctl3", v, 'h05);
    chk("R1 preset", int'(preset), 1);
    chk("R1 enables", int'({main_en, sub_en, aux_en}), 0);

    // R2 write timing and readback
    for (int a = 0; a < 4; a++) begin
      logic [7:0] pat;
      pat = 8'h5a ^ 8'(a * 37);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = 2'(a); wdata = pat;
      #1; chk("R2 old before edge", int'(rdata), int'(clk_div_pkg::reg_rst(a)));
      @(posedge clk); #1;
      wr_en = 1'b0;
      chk("R2 new after edge", int'(rdata), int'(pat));
    end
    wr(2'd0, 8'h60); wr(2'd1, 8'h87); wr(2'd2, 8'h00); wr(2'd3, 8'h05);
    idle(2);

    // R9 preset sweep, modulation field varied
    for (int st = 0; st < 8; st++) begin
      for (int rg = 0; rg < 16; rg++) begin
        wr(2'd0, {3'(st), 5'(st * 7 + rg)});
        wr(2'd1, {4'h8, 4'(rg)});
        #1; chk("R9 preset", int'(preset), preset_exp(st, rg));
      end
    end
    wr(2'd0, 8'h60); wr(2'd1, 8'h87);
    idle(2);

    // R3 R4 R5 R6 divider sweep
    for (int k = 0; k < 128; k++) begin
      int ms, md, ss, sd, ad;
      ms = (k >> 5) & 3; md = (k >> 3) & 3; ss = (k >> 2) & 1; sd = k & 3;
      ad = (k + (k >> 2)) & 3;
      wr(2'd2, {2'(ms), 2'(md), 1'(ss), 2'(sd), 1'b0});
      wr(2'd1, {2'b10, 2'(ad), 4'h7});
      idle(2);
      zero_counts();
      ticks(48, 1'b1);
      chk("R3/R4 main", n_main, main_exp_cnt(ms, md));
      chk("R5 sub", n_sub, ss ? (16 >> sd) : (48 >> sd));
      chk("R6 aux", n_aux, 16 >> ad);
    end

    // R8 pulse lands the cycle after the tick
    wr(2'd2, 8'h00);
    idle(2);
    fast = 1'b1; @(posedge clk); #1; fast = 1'b0;
    @(negedge clk); chk("R8 pulse after tick", int'(main_en), 1);
    @(posedge clk); #1;
    @(negedge clk); chk("R8 no pulse without tick", int'(main_en), 0);
    idle(1);

    // R7 restart on divider change
    wr(2'd2, 8'h30);
    idle(2);
    ticks(5, 1'b0);
    wr(2'd2, 8'h20);
    idle(2);
    zero_counts();
    ticks(3, 1'b0);
    chk("R7 none before full period", n_main, 0);
    ticks(1, 1'b0);
    chk("R7 first pulse after 4 ticks", n_main, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule